// File: doc/BRIEF.md
# Optical-Black Dark Level Compensator

This block removes the dark offset from a raw pixel stream. At the start of every frame the sensor delivers a run of optical-black (shielded) samples ahead of the image. The block averages the first 1024 of them into a per-frame black estimate. It then smooths that estimate from frame to frame with a small recursive filter whose gains are selected by 2-bit codes. Each active pixel that follows has the filtered black level subtracted and a signed user offset added, and the result is clamped to the 10-bit pixel range. When compensation is switched off, the offset byte is treated as an unsigned value and subtracted from every pixel.

Several trigger controls decide which frames may refresh the filtered level. The level can be refreshed on every frame, only after a gain change, only after a shutter change, or only for a burst of one to four frames after the length trigger is raised. On all other frames the previous level is reused.

Pixels enter and leave through valid/ready streams. Each input beat carries two sideband flags that mark it as an optical-black sample or as an active pixel. Only active pixels produce an output beat. Optical-black beats and unflagged beats are consumed without any output. The input is accepted only when the single output register is empty or is being drained in the same cycle, so back-pressure on the output stalls every kind of input beat, optical-black beats included. An output beat holds its data until it is taken.

Top module: `black_level_comp`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R2: Every accepted beat with `in_act` = 1 produces exactly one output beat, and output beats keep input order. Accepted beats with `in_act` = 0 produce no output.
- R3: After a `frame_start` pulse, the black mean of the frame is floor(sum of the first 1024 accepted beats with `in_ob` = 1 / 1024). Any further black beats in that frame are ignored.
- R4: The filtered level L is held in units of 1/8. When the 1024th black beat is accepted on an enabled frame, L becomes a·(M + T)·8 + floor(b8·L8 / 8) in eighths. Here M is the new mean, T is the tap, L8 is the old level in eighths, `ff_gain_code` 0/1/2/3 selects a = 0, 0.5, 0.75 or 1, and `fb_gain_code` 0/1/2/3 selects b8 = 0, 4, 2 or 1 (b = 0, 0.5, 0.25 or 0.125).
- R5: The tap T is the previous frame's mean when `tap_reuse` = 0, and the current mean M when `tap_reuse` = 1. The previous mean is updated on every frame's 1024th black beat, whether or not the level changes.
- R6: With `comp_en` = 0, the output is max(0, pixel − `user_offset`), with all 8 offset bits taken as unsigned. The level is then not refreshed.
- R7: With `comp_en` = 1, the output is clamp(pixel − floor(L) ± `user_offset`[6:0], 0, 1023). The magnitude is added when `user_offset`[7] = 1 and subtracted when it is 0.
- R8: The level is refreshed only on a frame allowed by a trigger: `trig_always`, or `trig_gain` with a pending gain change, or `trig_shutter` with a pending shutter change, or `trig_length` with frames remaining. On any other frame the level is unchanged.
- R9: A pulse on `gain_changed` or `shutter_changed` makes that change pending. Every frame's 1024th black beat clears both pending flags.
- R10: A rising edge of `trig_length` loads `length_code` + 1 (code 00 gives 1 frame, 11 gives 4 frames) as the remaining count. Each frame's 1024th black beat decrements the count while it is non-zero.
- R11: After reset the level and the previous mean are zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a new frame |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 10 | Raw pixel value |
| in_ob | input | 1 | Beat is an optical-black sample |
| in_act | input | 1 | Beat is an active pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 10 | Corrected pixel |
| comp_en | input | 1 | Enable dark level compensation |
| ff_gain_code | input | 2 | Feed-forward gain code (a) |
| fb_gain_code | input | 2 | Feedback gain code (b) |
| tap_reuse | input | 1 | Use the current mean as the second tap |
| trig_always | input | 1 | Refresh the level on every frame |
| trig_gain | input | 1 | Refresh after a gain change |
| trig_shutter | input | 1 | Refresh after a shutter change |
| trig_length | input | 1 | Refresh for a burst of frames after its rising edge |
| length_code | input | 2 | Burst length minus one |
| gain_changed | input | 1 | Pulse: gain setting changed |
| shutter_changed | input | 1 | Pulse: shutter setting changed |
| user_offset | input | 8 | Offset byte (sign-magnitude or unsigned, see R6/R7) |

## Verification
The assertions assume that `frame_start` never coincides with a valid input beat, and that no beat carries both `in_ob` and `in_act`. They also assume that the gain codes, tap select, trigger enables and offset stay constant within a frame, and that the change pulses and a `trig_length` edge never fall on the cycle of a 1024th black beat. The bench meets these assumptions by changing every control and pulsing every change input only between frames, while the input is idle. Within a frame it drives one beat type at a time and applies random output back-pressure. This exercises the stall path on both black and active beats.

// File: rtl/blc_pkg.sv
package blc_pkg;
  // fractional bits of the filtered black level
  localparam int GAIN_FRAC = 3;

  typedef logic [1:0] gcode_t;

  typedef struct packed {
    logic every;
    logic on_gain;
    logic on_shut;
    logic on_len;
  } trig_t;

  // feed-forward gain in units of 2^-GAIN_FRAC: 0, 0.5, 0.75, 1
  function automatic logic [GAIN_FRAC:0] ff_num(input gcode_t c);
    case (c)
      2'd0:    return '0;
      2'd1:    return (GAIN_FRAC+1)'(1) << (GAIN_FRAC-1);
      2'd2:    return (GAIN_FRAC+1)'(3) << (GAIN_FRAC-2);
      default: return (GAIN_FRAC+1)'(1) << GAIN_FRAC;
    endcase
  endfunction

  // feedback gain in units of 2^-GAIN_FRAC: 0, 0.5, 0.25, 0.125
  function automatic logic [GAIN_FRAC:0] fb_num(input gcode_t c);
    case (c)
      2'd0:    return '0;
      2'd1:    return (GAIN_FRAC+1)'(1) << (GAIN_FRAC-1);
      2'd2:    return (GAIN_FRAC+1)'(1) << (GAIN_FRAC-2);
      default: return (GAIN_FRAC+1)'(1) << (GAIN_FRAC-3);
    endcase
  endfunction
endpackage

// File: rtl/blc_ob_mean.sv
module blc_ob_mean #(
  parameter int PIX_W = 10,
  parameter int OB_N  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  output logic             mean_stb,
  output logic [PIX_W-1:0] mean
);
  localparam int LOG_N = $clog2(OB_N);
  localparam int SUM_W = PIX_W + LOG_N;
  localparam int CNT_W = LOG_N + 1;

  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] sum_all;
  logic             open;

  assign open     = cnt < CNT_W'(OB_N);
  assign sum_all  = sum + SUM_W'(pix);
  assign mean_stb = take && (cnt == CNT_W'(OB_N - 1));
  assign mean     = sum_all[SUM_W-1 -: PIX_W];

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      cnt <= '0;
      sum <= '0;
    end else if (take && open) begin
      cnt <= cnt + 1'b1;
      sum <= sum_all;
    end
  end

  // count never runs past the sample window (R3)
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(OB_N));
endmodule

// File: rtl/blc_iir.sv
module blc_iir
  import blc_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int DI_W  = PIX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mean_stb,
  input  logic [PIX_W-1:0] mean,
  input  logic             comp_en,
  input  gcode_t           a_code,
  input  gcode_t           b_code,
  input  logic             tap_sel,
  input  trig_t            trig,
  input  logic [1:0]       len_code,
  input  logic             gain_chg,
  input  logic             shut_chg,
  output logic [DI_W-1:0]  d_int
);
  localparam int D_W   = DI_W + GAIN_FRAC;
  localparam int P_W   = D_W + GAIN_FRAC + 1;
  localparam int D_MAX = 4 * ((1 << PIX_W) - 1) * (1 << GAIN_FRAC);

  logic [D_W-1:0]   d_q, d_next, ff_term;
  logic [P_W-1:0]   fb_prod;
  logic [PIX_W-1:0] prev, tap;
  logic [PIX_W:0]   pair;
  logic             gain_seen, shut_seen, len_q, allow;
  logic [2:0]       len_left;

  assign tap     = tap_sel ? mean : prev;
  assign pair    = {1'b0, mean} + {1'b0, tap};
  assign ff_term = D_W'(ff_num(a_code)) * D_W'(pair);
  assign fb_prod = P_W'(fb_num(b_code)) * P_W'(d_q);
  assign d_next  = ff_term + D_W'(fb_prod >> GAIN_FRAC);
  assign d_int   = d_q[D_W-1:GAIN_FRAC];

  assign allow = comp_en && (trig.every
                 || (trig.on_gain && gain_seen)
                 || (trig.on_shut && shut_seen)
                 || (trig.on_len && (len_left != 3'd0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q       <= '0;
      prev      <= '0;
      gain_seen <= 1'b0;
      shut_seen <= 1'b0;
      len_q     <= 1'b0;
      len_left  <= '0;
    end else begin
      len_q <= trig.on_len;
      if (trig.on_len && !len_q)
        len_left <= {1'b0, len_code} + 3'd1;
      else if (mean_stb && (len_left != 3'd0))
        len_left <= len_left - 3'd1;
      if (gain_chg)      gain_seen <= 1'b1;
      else if (mean_stb) gain_seen <= 1'b0;
      if (shut_chg)      shut_seen <= 1'b1;
      else if (mean_stb) shut_seen <= 1'b0;
      if (mean_stb) begin
        prev <= mean;
        if (allow) d_q <= d_next;
      end
    end
  end

  // level moves only on a window-complete strobe (R8)
  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mean_stb |=> $stable(d_q));
  // level stays within the bound of the recursion (R4)
  p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_q <= D_W'(D_MAX));
  // burst counter never exceeds four frames (R10)
  p_len_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_left <= 3'd4);
endmodule

// File: rtl/blc_apply.sv
module blc_apply #(
  parameter int PIX_W = 10,
  parameter int DI_W  = PIX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_take,
  input  logic [PIX_W-1:0] pix,
  input  logic             comp_en,
  input  logic [DI_W-1:0]  d_int,
  input  logic [7:0]       offset,
  input  logic             out_ready,
  output logic             can_take,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data
);
  localparam int VW = DI_W + 2;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic signed [VW-1:0] v, pix_s, mag_s;
  logic [PIX_W-1:0]     res;

  assign can_take = !out_valid || out_ready;
  assign pix_s    = signed'(VW'(pix));
  assign mag_s    = signed'(VW'(offset[6:0]));

  always_comb begin
    if (comp_en)
      v = pix_s - signed'(VW'(d_int)) + (offset[7] ? mag_s : -mag_s);
    else
      v = pix_s - signed'(VW'(offset));
    if (v < 0)
      res = '0;
    else if (v > signed'(VW'(PIX_MAX)))
      res = PIX_MAX;
    else
      res = v[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (act_take) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // stalled beat holds (R1)
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // a new output beat comes only from an accepted active pixel (R2)
  p_src_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(act_take));
  // unsigned subtraction never raises a pixel (R6)
  p_nocomp_le_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_take && !comp_en |=> out_data <= $past(pix));
endmodule

// File: rtl/black_level_comp.sv
module black_level_comp
  import blc_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int OB_N  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_ob,
  input  logic             in_act,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  input  logic             comp_en,
  input  logic [1:0]       ff_gain_code,
  input  logic [1:0]       fb_gain_code,
  input  logic             tap_reuse,
  input  logic             trig_always,
  input  logic             trig_gain,
  input  logic             trig_shutter,
  input  logic             trig_length,
  input  logic [1:0]       length_code,
  input  logic             gain_changed,
  input  logic             shutter_changed,
  input  logic [7:0]       user_offset
);
  localparam int DI_W = PIX_W + 3;

  logic             ob_take, act_take, mean_stb;
  logic [PIX_W-1:0] mean;
  logic [DI_W-1:0]  d_int;
  trig_t            trig;

  assign ob_take  = in_valid && in_ready && in_ob;
  assign act_take = in_valid && in_ready && in_act;
  assign trig     = '{every: trig_always, on_gain: trig_gain,
                      on_shut: trig_shutter, on_len: trig_length};

  blc_ob_mean #(.PIX_W(PIX_W), .OB_N(OB_N)) u_mean (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .take(ob_take), .pix(in_data), .mean_stb(mean_stb), .mean(mean)
  );

  blc_iir #(.PIX_W(PIX_W), .DI_W(DI_W)) u_iir (
    .clk(clk), .rst_n(rst_n), .mean_stb(mean_stb), .mean(mean),
    .comp_en(comp_en), .a_code(ff_gain_code), .b_code(fb_gain_code),
    .tap_sel(tap_reuse), .trig(trig), .len_code(length_code),
    .gain_chg(gain_changed), .shut_chg(shutter_changed), .d_int(d_int)
  );

  blc_apply #(.PIX_W(PIX_W), .DI_W(DI_W)) u_apply (
    .clk(clk), .rst_n(rst_n), .act_take(act_take), .pix(in_data),
    .comp_en(comp_en), .d_int(d_int), .offset(user_offset),
    .out_ready(out_ready), .can_take(in_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/black_level_comp_tb.sv
module black_level_comp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOB = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, in_valid = 0, in_ob = 0, in_act = 0, out_ready = 1;
  logic [9:0] in_data = '0;
  logic in_ready, out_valid;
  logic [9:0] out_data;
  logic comp_en = 1, tap_reuse = 0;
  logic [1:0] ff_gain_code = 2'd1, fb_gain_code = 2'd2, length_code = 2'd0;
  logic trig_always = 0, trig_gain = 0, trig_shutter = 0, trig_length = 0;
  logic gain_changed = 0, shutter_changed = 0;
  logic [7:0] user_offset = 8'h85;

  always #(CLK_PERIOD/2) clk = ~clk;

  black_level_comp u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_ob(in_ob), .in_act(in_act), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .comp_en(comp_en),
    .ff_gain_code(ff_gain_code), .fb_gain_code(fb_gain_code),
    .tap_reuse(tap_reuse), .trig_always(trig_always), .trig_gain(trig_gain),
    .trig_shutter(trig_shutter), .trig_length(trig_length),
    .length_code(length_code), .gain_changed(gain_changed),
    .shutter_changed(shutter_changed), .user_offset(user_offset)
  );

  int n_checks = 0, n_fail = 0;
  int m_d = 0, m_prev = 0, m_len = 0, m_cnt = 0, m_sum = 0;
  bit m_gs = 0, m_ss = 0;
  int n_act_sent = 0, n_out_seen = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R11";
  bit busy_bp = 1;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int a8(input int c);
    case (c) 0: return 0; 1: return 4; 2: return 6; default: return 8; endcase
  endfunction
  function automatic int b8(input int c);
    case (c) 0: return 0; 1: return 4; 2: return 2; default: return 1; endcase
  endfunction

  function automatic int ref_out(input int pix);
    int v;
    if (comp_en) begin
      v = pix - (m_d >>> 3);
      if (user_offset[7]) v = v + int'(user_offset[6:0]);
      else                v = v - int'(user_offset[6:0]);
    end else begin
      v = pix - int'(user_offset);
    end
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  // R3/R4/R5/R8/R9/R10 model step at the window-complete beat
  task automatic model_window();
    int mean, tapv;
    bit allow;
    mean = m_sum >>> 10;
    tapv = tap_reuse ? mean : m_prev;
    allow = comp_en && (trig_always || (trig_gain && m_gs) ||
            (trig_shutter && m_ss) || (trig_length && m_len != 0));
    if (allow) m_d = a8(ff_gain_code) * (mean + tapv) + ((b8(fb_gain_code) * m_d) >>> 3);
    m_prev = mean;
    m_gs = 0; m_ss = 0;
    if (m_len > 0) m_len--;
  endtask

  // output back-pressure
  always @(posedge clk) begin
    #1;
    out_ready = busy_bp ? (($urandom % 4) != 0) : 1'b1;
  end

  // output monitor, samples mid-cycle
  bit stalled = 0;
  int stall_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) check(out_valid && out_data == 10'(stall_data), "R1", int'(out_data), stall_data);
      check(in_ready == (!out_valid || out_ready), "R1", int'(in_ready), int'(!out_valid || out_ready));
      stalled = out_valid && !out_ready;
      stall_data = int'(out_data);
      if (out_valid && out_ready) begin
        n_out_seen++;
        if (exp_q.size() == 0) begin
          check(0, "R2", n_out_seen, n_act_sent);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(out_data) == e, t, int'(out_data), e);
        end
      end
    end
  end

  task automatic send(input int pix, input bit ob, input bit act);
    in_valid = 1; in_data = 10'(pix); in_ob = ob; in_act = act;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0; in_ob = 0; in_act = 0;
    if (act) begin
      exp_q.push_back(ref_out(pix));
      tag_q.push_back(cur_tag);
      n_act_sent++;
    end
    if (ob && m_cnt < NOB) begin
      m_sum += pix;
      m_cnt++;
      if (m_cnt == NOB) model_window();
    end
  endtask

  task automatic pulse_frame();
    frame_start = 1;
    @(posedge clk); #1;
    frame_start = 0;
    m_cnt = 0; m_sum = 0;
  endtask

  task automatic pulse_gain();
    gain_changed = 1; @(posedge clk); #1; gain_changed = 0; m_gs = 1;
  endtask
  task automatic pulse_shut();
    shutter_changed = 1; @(posedge clk); #1; shutter_changed = 0; m_ss = 1;
  endtask

  task automatic set_len(input bit v, input int code);
    if (v && !trig_length) m_len = code + 1;
    trig_length = v;
    length_code = 2'(code);
    @(posedge clk); #1;
  endtask

  task automatic run_frame(input string tag, input int ob_base, input int ob_span,
                           input int extra_ob, input int n_act);
    cur_tag = tag;
    pulse_frame();
    repeat ($urandom % 3) send(int'($urandom % 1024), 0, 0);
    for (int i = 0; i < NOB; i++) begin
      int v;
      v = ob_base + int'($urandom % ob_span);
      if (v > 1023) v = 1023;
      send(v, 1, 0);
    end
    for (int i = 0; i < extra_ob; i++) send(1023, 1, 0);
    send(0, 0, 1);
    send(1023, 0, 1);
    for (int i = 0; i < n_act; i++) begin
      send(int'($urandom % 1024), 0, 1);
      if (($urandom % 4) == 0) send(int'($urandom % 1024), 0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bc7));
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", int'(out_valid), 0);
    check(in_ready == 1'b1, "R11", int'(in_ready), 1);
    @(posedge clk); #1;

    // no trigger: level stays zero after reset
    run_frame("R11", 100, 20, 0, 12);
    run_frame("R8", 200, 30, 0, 10);

    trig_always = 1;
    run_frame("R4", 60, 16, 0, 12);
    ff_gain_code = 2'd2; fb_gain_code = 2'd3;
    run_frame("R4", 90, 9, 0, 12);
    ff_gain_code = 2'd3; fb_gain_code = 2'd1;
    run_frame("R4", 30, 50, 0, 12);
    ff_gain_code = 2'd0; fb_gain_code = 2'd1;
    run_frame("R4", 30, 50, 0, 8);
    ff_gain_code = 2'd1; fb_gain_code = 2'd2;

    tap_reuse = 1;
    run_frame("R5", 150, 40, 0, 10);
    tap_reuse = 0;
    run_frame("R5", 20, 10, 0, 8);

    comp_en = 0; user_offset = 8'd200;
    run_frame("R6", 300, 40, 0, 12);

    comp_en = 1; user_offset = 8'h7F;
    run_frame("R7", 300, 20, 0, 12);
    user_offset = 8'hFF;
    run_frame("R7", 0, 4, 0, 8);
    run_frame("R7", 0, 4, 0, 8);

    trig_always = 0; trig_gain = 1; user_offset = 8'h80;
    run_frame("R8", 400, 30, 0, 8);
    pulse_gain();
    run_frame("R9", 400, 30, 0, 8);
    run_frame("R9", 700, 30, 0, 8);
    trig_gain = 0; trig_shutter = 1;
    pulse_shut();
    run_frame("R9", 250, 30, 0, 8);
    trig_shutter = 0;

    set_len(1, 1);
    run_frame("R10", 500, 20, 0, 6);
    run_frame("R10", 100, 20, 0, 6);
    run_frame("R10", 900, 20, 0, 6);
    set_len(0, 0);

    trig_always = 1;
    run_frame("R3", 80, 30, 7, 8);

    for (int f = 0; f < 5; f++) begin
      ff_gain_code = 2'($urandom); fb_gain_code = 2'($urandom);
      tap_reuse = 1'($urandom); user_offset = 8'($urandom);
      comp_en = (($urandom % 4) != 0);
      trig_always = 1'($urandom);
      trig_gain = 1'($urandom);
      if (($urandom % 2) == 0) pulse_gain();
      run_frame("R7", int'($urandom % 900), 1 + int'($urandom % 120), 0, 10);
    end

    busy_bp = 0;
    repeat (50) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(n_out_seen == n_act_sent, "R2", n_out_seen, n_act_sent);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule